// File: doc/BRIEF.md
# Instruction Byte Stream Decoder

This block sits behind an instruction byte source and turns a flat stream of bytes into whole instructions of a small 16-bit register machine. Bytes arrive one per handshake on a valid/ready port. The first byte of each instruction is an opcode. The decoder decides from that byte alone whether the instruction is one byte long or whether a 16-bit operand follows. When an operand follows, the decoder gathers the next two bytes into it.

When an instruction is complete, the block presents one decoded record on its output port and holds it until downstream accepts it. The record carries the operation class, the register field, the mode field, an operand-present flag, the operand, the length in bytes and an illegal flag. Encodings that are not defined are reported as one-byte illegal records. This keeps the stream aligned on the byte that follows them.

Top module: `instr_byte_decoder`

## Requirements
- R1: The opcode byte splits into a class field in bits 7:5, a register field in bits 4:3 and a mode field in bits 2:0. Every legal record reports bits 4:3 on `rec_reg_o` and bits 2:0 on `rec_mode_o`.
- R2: For class fields 001 to 111, `rec_class_o` is the class field plus 4: OR=5, AND=6, CMP=7, SUB=8, ADD=9, MOVE=10, STORE=11.
- R3: For class fields 001 to 110, an operand is present exactly when the mode field is 101, 110 or 111. `rec_len_o` is 3 when an operand is present and 1 otherwise.
- R4: The operand is assembled with the first byte after the opcode as bits 7:0 and the second byte as bits 15:8.
- R5: Opcodes 00h, 01h and 02h decode to HALT (class 0), GET (class 1) and PUT (class 2), each one byte long. Opcodes 03h to 07h are illegal.
- R6: Opcodes 08h to 0Eh decode to JUMP (class 3) with an operand and a length of 3, and the condition appears on `rec_mode_o`. Opcode 0Fh is illegal.
- R7: Opcodes 10h to 16h decode to NOT (class 4), which carries an operand only for mode 101 or 110. Opcode 17h and all opcodes 18h to 1Fh are illegal.
- R8: A STORE (class field 111) is legal only for mode 100, 101 or 110, and carries an operand for mode 101 or 110. Mode values 000 to 011 and 111 make it illegal.
- R9: An illegal opcode yields class 15, `rec_illegal_o`=1, length 1, no operand and an operand value of 0. The byte that follows it is decoded as a new opcode.
- R10: A record becomes valid in the cycle after its last byte is accepted. While a record is valid and not yet accepted, `byte_ready_o` is low and every record field stays unchanged.
- R11: After reset no record is valid, `byte_ready_o` is high, and the first byte accepted is treated as an opcode.
- R12: A record without an operand reports an operand value of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| byte_valid_i | input | 1 | Incoming byte is valid |
| byte_data_i | input | 8 | Incoming instruction byte |
| byte_ready_o | output | 1 | Decoder accepts a byte this cycle |
| rec_valid_o | output | 1 | Decoded record is valid |
| rec_ready_i | input | 1 | Downstream accepts the record |
| rec_class_o | output | 4 | Operation class code |
| rec_reg_o | output | 2 | Register field of the opcode |
| rec_mode_o | output | 3 | Mode or condition field of the opcode |
| rec_has_imm_o | output | 1 | Record carries a 16-bit operand |
| rec_imm_o | output | 16 | Operand value, low byte first in the stream |
| rec_len_o | output | 2 | Instruction length in bytes (1 or 3) |
| rec_illegal_o | output | 1 | Opcode is illegal |

## Verification
The assertions assume that the byte source and the record consumer obey the handshake. A byte counts only in a cycle where valid and ready are both high. The consumer may hold the record for any number of cycles. The stimulus drives bytes only between clock edges, never drops a byte it has raised until that byte is taken, and raises the record acceptance for exactly one edge after a varied number of stall cycles. The sweep covers all 256 opcode values in sequence. The operand bytes differ for each opcode, so a swapped or stale operand byte would show in the checks.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;
  localparam int BYTE_W    = 8;
  localparam int IMM_BYTES = 2;
  localparam int IMM_W     = BYTE_W * IMM_BYTES;
  localparam int LEN_W     = $clog2(IMM_BYTES + 2);
  localparam int CNT_W     = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;

  typedef enum logic [3:0] {
    CL_HALT  = 4'd0,
    CL_GET   = 4'd1,
    CL_PUT   = 4'd2,
    CL_JUMP  = 4'd3,
    CL_NOT   = 4'd4,
    CL_OR    = 4'd5,
    CL_AND   = 4'd6,
    CL_CMP   = 4'd7,
    CL_SUB   = 4'd8,
    CL_ADD   = 4'd9,
    CL_MOVE  = 4'd10,
    CL_STORE = 4'd11,
    CL_BAD   = 4'd15
  } op_class_e;

  typedef struct packed {
    op_class_e         cls;
    logic [1:0]        rsel;
    logic [2:0]        mode;
    logic              has_imm;
    logic [IMM_W-1:0]  imm;
    logic [LEN_W-1:0]  len;
    logic              bad;
  } dec_rec_t;
endpackage

// File: rtl/dec_rst_sync.sv
module dec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/opcode_classifier.sv
module opcode_classifier
  import instr_dec_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode_i,
  output op_class_e         cls_o,
  output logic              has_imm_o,
  output logic              bad_o
);
  logic [2:0] grp;
  logic [1:0] rsel;
  logic [2:0] mode;
  logic       mode_disp;
  logic       mode_any_imm;

  assign grp          = opcode_i[7:5];
  assign rsel         = opcode_i[4:3];
  assign mode         = opcode_i[2:0];
  assign mode_disp    = (mode == 3'b101) || (mode == 3'b110);
  assign mode_any_imm = mode_disp || (mode == 3'b111);

  always_comb begin
    cls_o     = CL_BAD;
    has_imm_o = 1'b0;
    bad_o     = 1'b1;
    unique case (grp)
      3'b000: begin
        unique case (rsel)
          2'b00: begin
            bad_o = 1'b0;
            unique case (mode)
              3'b000:  cls_o = CL_HALT;
              3'b001:  cls_o = CL_GET;
              3'b010:  cls_o = CL_PUT;
              default: bad_o = 1'b1;
            endcase
          end
          2'b01: begin
            if (mode != 3'b111) begin
              cls_o     = CL_JUMP;
              has_imm_o = 1'b1;
              bad_o     = 1'b0;
            end
          end
          2'b10: begin
            if (mode != 3'b111) begin
              cls_o     = CL_NOT;
              has_imm_o = mode_disp;
              bad_o     = 1'b0;
            end
          end
          default: ;
        endcase
      end
      3'b111: begin
        if (mode[2] && (mode != 3'b111)) begin
          cls_o     = CL_STORE;
          has_imm_o = mode_disp;
          bad_o     = 1'b0;
        end
      end
      default: begin
        cls_o     = op_class_e'({1'b0, grp} + 4'd4);
        has_imm_o = mode_any_imm;
        bad_o     = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/byte_sequencer.sv
module byte_sequencer
  import instr_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  output logic              byte_ready_o,
  input  op_class_e         op_cls_i,
  input  logic              op_has_imm_i,
  input  logic              op_bad_i,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output dec_rec_t          rec_o
);
  typedef enum logic {ST_OPC, ST_IMM} seq_st_e;

  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(1 + IMM_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(IMM_BYTES - 1);

  seq_st_e          st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  dec_rec_t         rec_q, rec_n;
  logic             vld_q, vld_n;
  logic             take, drain, upd_en;

  assign byte_ready_o = !vld_q;
  assign take         = byte_valid_i && byte_ready_o;
  assign drain        = vld_q && rec_ready_i;
  assign upd_en       = take || drain;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    rec_n = rec_q;
    vld_n = vld_q;
    if (drain) vld_n = 1'b0;
    if (take) begin
      unique case (st_q)
        ST_OPC: begin
          rec_n.cls     = op_cls_i;
          rec_n.rsel    = byte_data_i[4:3];
          rec_n.mode    = byte_data_i[2:0];
          rec_n.has_imm = op_has_imm_i;
          rec_n.imm     = '0;
          rec_n.len     = op_has_imm_i ? LEN_LONG : LEN_SHORT;
          rec_n.bad     = op_bad_i;
          cnt_n         = '0;
          if (op_has_imm_i) st_n = ST_IMM;
          else              vld_n = 1'b1;
        end
        ST_IMM: begin
          rec_n.imm[cnt_q*BYTE_W +: BYTE_W] = byte_data_i;
          if (cnt_q == CNT_LAST) begin
            st_n  = ST_OPC;
            vld_n = 1'b1;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
        default: st_n = ST_OPC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OPC;
      cnt_q <= '0;
      rec_q <= '0;
      vld_q <= 1'b0;
    end else if (upd_en) begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      rec_q <= rec_n;
      vld_q <= vld_n;
    end
  end

  assign rec_valid_o = vld_q;
  assign rec_o       = rec_q;
endmodule

// File: rtl/instr_byte_decoder.sv
module instr_byte_decoder
  import instr_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  output logic              byte_ready_o,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [3:0]        rec_class_o,
  output logic [1:0]        rec_reg_o,
  output logic [2:0]        rec_mode_o,
  output logic              rec_has_imm_o,
  output logic [IMM_W-1:0]  rec_imm_o,
  output logic [LEN_W-1:0]  rec_len_o,
  output logic              rec_illegal_o
);
  logic      rst_int_n;
  op_class_e op_cls;
  logic      op_has_imm;
  logic      op_bad;
  dec_rec_t  rec;

  dec_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  opcode_classifier u_cls (
    .opcode_i  (byte_data_i),
    .cls_o     (op_cls),
    .has_imm_o (op_has_imm),
    .bad_o     (op_bad)
  );

  byte_sequencer u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .byte_valid_i (byte_valid_i),
    .byte_data_i  (byte_data_i),
    .byte_ready_o (byte_ready_o),
    .op_cls_i     (op_cls),
    .op_has_imm_i (op_has_imm),
    .op_bad_i     (op_bad),
    .rec_valid_o  (rec_valid_o),
    .rec_ready_i  (rec_ready_i),
    .rec_o        (rec)
  );

  assign rec_class_o   = rec.cls;
  assign rec_reg_o     = rec.rsel;
  assign rec_mode_o    = rec.mode;
  assign rec_has_imm_o = rec.has_imm;
  assign rec_imm_o     = rec.imm;
  assign rec_len_o     = rec.len;
  assign rec_illegal_o = rec.bad;
endmodule

// File: rtl/instr_byte_decoder_chk.sv
module instr_byte_decoder_chk
  import instr_dec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              byte_valid_i,
  input logic              byte_ready_o,
  input logic              rec_valid_o,
  input logic              rec_ready_i,
  input logic [3:0]        rec_class_o,
  input logic [1:0]        rec_reg_o,
  input logic [2:0]        rec_mode_o,
  input logic              rec_has_imm_o,
  input logic [IMM_W-1:0]  rec_imm_o,
  input logic [LEN_W-1:0]  rec_len_o,
  input logic              rec_illegal_o
);
  // Stalled record keeps every field until accepted
  assert_record_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_imm_o) &&
      $stable(rec_class_o) && $stable(rec_reg_o) && $stable(rec_mode_o) &&
      $stable(rec_len_o) && $stable(rec_has_imm_o) && $stable(rec_illegal_o));

  // A record appears only after a byte handshake
  assert_record_after_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_valid_o) |-> $past(byte_valid_i && byte_ready_o));

  assert_illegal_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o && rec_illegal_o |-> rec_len_o == LEN_W'(1) && !rec_has_imm_o &&
      rec_imm_o == '0 && rec_class_o == 4'd15);

  assert_len_matches_imm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> rec_has_imm_o == (rec_len_o == LEN_W'(1 + IMM_BYTES)));

  assert_jump_has_operand_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o && rec_class_o == 4'd3 |-> rec_has_imm_o);

  assert_no_operand_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o && !rec_has_imm_o |-> rec_imm_o == '0);
endmodule

bind instr_byte_decoder instr_byte_decoder_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .byte_valid_i  (byte_valid_i),
  .byte_ready_o  (byte_ready_o),
  .rec_valid_o   (rec_valid_o),
  .rec_ready_i   (rec_ready_i),
  .rec_class_o   (rec_class_o),
  .rec_reg_o     (rec_reg_o),
  .rec_mode_o    (rec_mode_o),
  .rec_has_imm_o (rec_has_imm_o),
  .rec_imm_o     (rec_imm_o),
  .rec_len_o     (rec_len_o),
  .rec_illegal_o (rec_illegal_o)
);

// File: tb/instr_byte_decoder_test.sv
`timescale 1ns/1ps
module instr_byte_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_data_i = 8'h00;
  logic        byte_ready_o;
  logic        rec_valid_o;
  logic        rec_ready_i = 1'b0;
  logic [3:0]  rec_class_o;
  logic [1:0]  rec_reg_o;
  logic [2:0]  rec_mode_o;
  logic        rec_has_imm_o;
  logic [15:0] rec_imm_o;
  logic [1:0]  rec_len_o;
  logic        rec_illegal_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  instr_byte_decoder uut (
    .clk(clk), .rst_n(rst_n),
    .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i), .byte_ready_o(byte_ready_o),
    .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i),
    .rec_class_o(rec_class_o), .rec_reg_o(rec_reg_o), .rec_mode_o(rec_mode_o),
    .rec_has_imm_o(rec_has_imm_o), .rec_imm_o(rec_imm_o), .rec_len_o(rec_len_o),
    .rec_illegal_o(rec_illegal_o)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Expected record from the requirement text, by opcode range
  task automatic model(input logic [7:0] op, output logic [3:0] cls, output logic imm,
                       output logic bad);
    logic [2:0] lo3;
    lo3 = op[2:0];
    cls = 4'd15; imm = 1'b0; bad = 1'b1;
    if (op <= 8'h02) begin cls = op[3:0]; bad = 1'b0; end              // R5
    else if (op >= 8'h08 && op <= 8'h0E) begin cls = 4'd3; imm = 1'b1; bad = 1'b0; end // R6
    else if (op >= 8'h10 && op <= 8'h16) begin                          // R7
      cls = 4'd4; bad = 1'b0; imm = (lo3 == 3'd5) || (lo3 == 3'd6);
    end else if (op >= 8'h20 && op <= 8'hDF) begin                      // R2, R3
      cls = 4'(op / 32) + 4'd4; bad = 1'b0; imm = (lo3 >= 3'd5);
    end else if (op >= 8'hE0) begin                                     // R8
      if (lo3 >= 3'd4 && lo3 <= 3'd6) begin
        cls = 4'd11; bad = 1'b0; imm = (lo3 != 3'd4);
      end
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    byte_valid_i = 1'b1;
    byte_data_i  = b;
    while (!byte_ready_o) @(negedge clk);
    @(posedge clk);
    #1;
    byte_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 reset rec_valid", 32'(rec_valid_o), 32'd0);
    check("R11 reset byte_ready", 32'(byte_ready_o), 32'd1);

    for (int op = 0; op < 256; op++) begin
      logic [3:0] ecls; logic eimm; logic ebad;
      logic [7:0] lo, hi;
      logic [15:0] eval;
      logic [1:0] elen;
      model(8'(op), ecls, eimm, ebad);
      lo   = 8'(op) ^ 8'hA5;
      hi   = 8'(op) + 8'h3C;
      eval = eimm ? {hi, lo} : 16'h0000;
      elen = eimm ? 2'd3 : 2'd1;
      push(8'(op));
      if (eimm) begin
        check($sformatf("R10 no record mid-operand op=%0h", op), 32'(rec_valid_o), 32'd0);
        push(lo);
        check($sformatf("R10 no record before high byte op=%0h", op), 32'(rec_valid_o), 32'd0);
        push(hi);
      end
      check($sformatf("R10 record valid op=%0h", op), 32'(rec_valid_o), 32'd1);
      check($sformatf("R2 R5 R6 R7 R8 class op=%0h", op), 32'(rec_class_o), 32'(ecls));
      check($sformatf("R9 illegal op=%0h", op), 32'(rec_illegal_o), 32'(ebad));
      check($sformatf("R3 has operand op=%0h", op), 32'(rec_has_imm_o), 32'(eimm));
      check($sformatf("R3 length op=%0h", op), 32'(rec_len_o), 32'(elen));
      check($sformatf("R4 R12 operand op=%0h", op), 32'(rec_imm_o), 32'(eval));
      if (!ebad) begin
        check($sformatf("R1 reg field op=%0h", op), 32'(rec_reg_o), 32'(op / 8 % 4));
        check($sformatf("R1 mode field op=%0h", op), 32'(rec_mode_o), 32'(op % 8));
      end
      for (int k = 0; k < op % 3; k++) begin
        @(negedge clk);
        check($sformatf("R10 stall ready low op=%0h", op), 32'(byte_ready_o), 32'd0);
        check($sformatf("R10 stall held operand op=%0h", op), 32'(rec_imm_o), 32'(eval));
        check($sformatf("R10 stall held class op=%0h", op), 32'(rec_class_o), 32'(ecls));
      end
      @(negedge clk);
      rec_ready_i = 1'b1;
      @(posedge clk);
      #1;
      rec_ready_i = 1'b0;
      check($sformatf("R10 record drained op=%0h", op), 32'(rec_valid_o), 32'd0);
      check($sformatf("R9 R11 ready for next opcode op=%0h", op), 32'(byte_ready_o), 32'd1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule